// File: doc/BRIEF.md
# Three-Source Edge Interrupt Controller

This block gathers three interrupt events and presents them as one interrupt line. The first event is a single-cycle strobe that marks a finished output pulse. The other two events come from one asynchronous over-temperature warning level. The block synchronises that level and splits it into two events: one when the warning asserts and one when it clears.

Each source has three bits: a raw flag, an enable bit and a pending bit. The raw flag records every event, whether the source is enabled or not. The pending bit records only events that occur while the source is enabled. Software clears a source by writing 1 to its bit. That write clears the pending bit and the raw flag together. The interrupt output is a registered OR of the three pending bits.

Register decode and bus timing belong to the enclosing system. Here the enable bits and the clear action are driven through plain write-enable and write-data ports.

Top module: `irq_tri_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `en_o`, `pend_o`, `raw_o`, `irq_o` and `warn_o` are all 0. Every source is therefore disabled out of reset.
- R2: Bit positions are fixed. Bit 0 is the pulse-done strobe. Bit 1 is the warning going from low to high. Bit 2 is the warning going from high to low.
- R3: An event sets its `raw_o` bit at the next clock edge, whatever the enable bit holds. The bit then stays set until it is cleared.
- R4: When `en_we_i` is high, `en_wdata_i` is loaded into `en_o` at the clock edge. When `en_we_i` is low, `en_o` holds its value. An enable bit of 1 lets its source through.
- R5: An event sets its `pend_o` bit at the next edge only if the enable bit is 1 in that cycle.
- R6: When `clr_we_i` is high, each 1 in `clr_wdata_i` clears that bit in both `pend_o` and `raw_o`. Bits written 0 keep their value. When `clr_we_i` is low, `clr_wdata_i` has no effect.
- R7: If an event and a clear hit the same bit in the same cycle, the bit is set after the edge.
- R8: `irq_o` equals the OR of `pend_o` as it stood one cycle earlier.
- R9: `warn_o` follows `warn_i` through two flops, so a change shows two edges later. The matching raw flag sets one edge after that.
- R10: Clearing an enable bit leaves a pending bit that is already set. Setting an enable bit does not raise pending for an event that is already recorded in the raw flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_done_i | input | 1 | One-cycle strobe: a pulse was produced |
| warn_i | input | 1 | Asynchronous over-temperature warning level |
| en_we_i | input | 1 | Write strobe for the enable bits |
| en_wdata_i | input | 3 | New enable bits |
| clr_we_i | input | 1 | Write strobe for write-1-to-clear |
| clr_wdata_i | input | 3 | Bits to clear in pending and raw |
| en_o | output | 3 | Enable bits |
| pend_o | output | 3 | Pending bits |
| raw_o | output | 3 | Raw source flags |
| warn_o | output | 1 | Synchronised warning level |
| irq_o | output | 1 | Registered OR of pending bits |

## Verification
Directed sequences come first.
- A strobe with the source disabled separates the raw flag from the pending bit.
- A strobe with the source enabled checks that pending sets and that `irq_o` follows one cycle later.
- A clear whose data carries a 1 but whose strobe is low shows that the strobe gates the clear.
- A strobe that lands in the same cycle as its clear checks that the event wins.
- A slow warning rise followed by a slow fall checks the two-flop latency and shows that entry and exit land on separate bits.
- A partial clear shows that the bits are independent.

After that, long random traffic runs. It toggles the warning fast, writes enables and clears at random, and sends random strobes. A behavioural model compares every output on every clock.

// File: rtl/irq_tri_ctrl.sv
module irq_tri_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse_done_i,
  input  logic       warn_i,
  input  logic       en_we_i,
  input  logic [2:0] en_wdata_i,
  input  logic       clr_we_i,
  input  logic [2:0] clr_wdata_i,
  output logic [2:0] en_o,
  output logic [2:0] pend_o,
  output logic [2:0] raw_o,
  output logic       warn_o,
  output logic       irq_o
);

  logic       warn_meta, warn_sync, warn_prev;
  logic [2:0] evt, clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {warn_meta, warn_sync, warn_prev} <= '0;
    else        {warn_meta, warn_sync, warn_prev} <= {warn_i, warn_meta, warn_sync};

  assign warn_o = warn_sync;
  assign evt    = {warn_prev & ~warn_sync, warn_sync & ~warn_prev, pulse_done_i};
  assign clr    = clr_we_i ? clr_wdata_i : 3'b000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_o   <= '0;
      pend_o <= '0;
      raw_o  <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (en_we_i) en_o <= en_wdata_i;
      raw_o  <= (raw_o & ~clr) | evt;
      pend_o <= (pend_o & ~clr) | (evt & en_o);
      irq_o  <= |pend_o;
    end

  a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(pend_o != 3'b000));

  a_r9_entry_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_o[1]) |-> $past(warn_o));

  a_r9_exit_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_o[2]) |-> !$past(warn_o));

  for (genvar i = 0; i < 3; i++) begin : g_chk
    a_r5_pend_implies_raw: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[i] |-> raw_o[i]);
    a_r5_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(pend_o[i]) && pend_o[i]) |-> $past(en_o[i]));
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && clr_wdata_i[i] && !evt[i]) |=> (!raw_o[i] && !pend_o[i]));
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> raw_o[i]);
  end

endmodule

// File: tb/irq_tri_ctrl_tb.sv
module irq_tri_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic pulse = 0, warn = 0, en_we = 0, clr_we = 0;
  logic [2:0] en_wd = 0, clr_wd = 0;
  logic [2:0] en_o, pend_o, raw_o;
  logic warn_o, irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_tri_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_done_i(pulse), .warn_i(warn),
    .en_we_i(en_we), .en_wdata_i(en_wd), .clr_we_i(clr_we), .clr_wdata_i(clr_wd),
    .en_o(en_o), .pend_o(pend_o), .raw_o(raw_o), .warn_o(warn_o), .irq_o(irq_o));

  bit [2:0] m_en, m_pend, m_raw, ev, cl;
  bit m_irq;
  bit hist [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pend = 0; m_raw = 0; m_irq = 0;
      hist = {1'b0, 1'b0, 1'b0};
    end else begin
      ev[0] = pulse;
      ev[1] = hist[1] && !hist[2];
      ev[2] = !hist[1] && hist[2];
      cl = clr_we ? clr_wd : 3'b000;
      m_irq = (m_pend != 0);
      m_raw = (m_raw & ~cl) | ev;
      m_pend = (m_pend & ~cl) | (ev & m_en);
      if (en_we) m_en = en_wd;
      hist.push_front(warn);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(en_o == m_en, "R4 en", en_o, m_en);
    chk(raw_o == m_raw, "R3 raw", raw_o, m_raw);
    chk(pend_o == m_pend, "R6 pend", pend_o, m_pend);
    chk(irq_o == m_irq, "R8 irq", irq_o, m_irq);
    chk(warn_o == hist[1], "R9 warn", warn_o, hist[1]);
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    #200000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({en_o, pend_o, raw_o, irq_o, warn_o} == 0, "R1 in reset", {en_o, pend_o, raw_o}, 0);
    rst_n = 1;
    tick();
    chk({en_o, pend_o, raw_o, irq_o, warn_o} == 0, "R1 after release", {en_o, pend_o, raw_o}, 0);

    pulse = 1; tick(); pulse = 0;
    chk(raw_o == 3'b001 && pend_o == 0, "R2 R3 disabled strobe", {raw_o, pend_o}, 6'o10);
    clr_we = 1; clr_wd = 3'b001; tick(); clr_we = 0;
    chk(raw_o == 0, "R6 clear raw", raw_o, 0);

    en_we = 1; en_wd = 3'b111; tick(); en_we = 0;
    chk(en_o == 3'b111, "R4 enable load", en_o, 7);
    en_wd = 3'b000; tick();
    chk(en_o == 3'b111, "R4 hold without strobe", en_o, 7);
    pulse = 1; tick(); pulse = 0;
    chk(pend_o == 3'b001 && irq_o == 0, "R5 pend set", pend_o, 1);
    tick();
    chk(irq_o == 1, "R8 irq one cycle later", irq_o, 1);

    clr_wd = 3'b111; tick();
    chk(pend_o == 3'b001, "R6 no strobe no clear", pend_o, 1);
    clr_we = 1; clr_wd = 3'b001; pulse = 1; tick(); clr_we = 0; pulse = 0;
    chk(pend_o == 3'b001 && raw_o == 3'b001, "R7 event beats clear", pend_o, 1);
    en_we = 1; en_wd = 3'b000; tick(); en_we = 0;
    chk(pend_o == 3'b001, "R10 disable keeps pend", pend_o, 1);
    clr_we = 1; clr_wd = 3'b001; tick(); clr_we = 0;
    tick();
    chk(pend_o == 0 && irq_o == 0, "R8 irq drops", irq_o, 0);

    pulse = 1; tick(); pulse = 0;
    en_we = 1; en_wd = 3'b111; tick(); en_we = 0;
    chk(raw_o == 3'b001 && pend_o == 0, "R10 late enable no pend", pend_o, 0);
    clr_we = 1; clr_wd = 3'b111; tick(); clr_we = 0;

    warn = 1; tick();
    chk(warn_o == 0, "R9 first stage", warn_o, 0);
    tick();
    chk(warn_o == 1 && raw_o == 0, "R9 two edges", warn_o, 1);
    tick();
    chk(raw_o == 3'b010 && pend_o == 3'b010, "R2 entry bit", raw_o, 2);
    warn = 0; repeat (3) tick();
    chk(raw_o == 3'b110, "R2 exit bit", raw_o, 6);
    clr_we = 1; clr_wd = 3'b010; tick(); clr_we = 0;
    chk(raw_o == 3'b100 && pend_o == 3'b100, "R6 partial clear", raw_o, 4);

    for (int i = 0; i < 4000; i++) begin
      pulse = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 5) == 0) warn = ~warn;
      en_we = ($urandom_range(0, 7) == 0); en_wd = 3'($urandom);
      clr_we = ($urandom_range(0, 3) == 0); clr_wd = 3'($urandom);
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule